// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a small synchronous controller for a keypad door lock. The user enters three values one at a time. Each entry arrives with a single-cycle strobe, and the door unlocks only when the three values match three stored codes in order. The codes come in on input ports. The block chooses which code to compare against and performs the comparison itself.

The controller has five states: three entry stages, an open state and an error state. The state register is encoded so that its outputs need no decoding. The low three bits form a one-hot code select, and the top bit drives the door. Any wrong entry sends the machine into a sticky error state. Only reset leaves that state. A successful unlock also stays put until reset.

Top module: `combo_lock`

## Requirements
- R1: While `rst_ni` is low, the machine is in the first stage: `sel_o` = 3'b001 and `open_o` = 0. Reset acts asynchronously and overrides `new_i`.
- R2: In any entry stage, a clock edge with `new_i` low leaves `sel_o` and `open_o` unchanged.
- R3: In the first stage, a strobed value equal to `code1_i` moves the machine to the second stage (`sel_o` = 3'b010). In the second stage, a strobed value equal to `code2_i` moves it to the third stage (`sel_o` = 3'b100).
- R4: In the third stage, a strobed value equal to `code3_i` moves the machine to the open state: `open_o` = 1 and `sel_o` = 3'b000.
- R5: In any entry stage, a strobed value that differs from the selected code moves the machine to the error state: `sel_o` = 3'b000 and `open_o` = 0.
- R6: The open state is kept on every clock edge, with or without strobes, until reset.
- R7: The error state is kept on every clock edge, with or without strobes, including strobes of correct codes, until reset.
- R8: Only the code picked by `sel_o` is compared. A strobed value that equals one of the other two codes but not the selected one counts as wrong.
- R9: At most one of the four bits {`open_o`, `sel_o`} is high at any time. An unused state code returns to the first stage on the next clock.
- R10: Asserting reset from the open state or from the error state returns the machine to the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; returns the lock to the first stage |
| new_i | input | 1 | Single-cycle strobe marking a fresh entered value |
| value_i | input | VAL_W | Entered value |
| code1_i | input | VAL_W | First code of the combination |
| code2_i | input | VAL_W | Second code of the combination |
| code3_i | input | VAL_W | Third code of the combination |
| sel_o | output | 3 | One-hot select of the code currently compared (000 outside entry stages) |
| open_o | output | 1 | Door output, 1 = open |

## Verification
The properties assume that `new_i` is high for one clock per entered value. They also assume that `value_i` and the code inputs are stable around each clock edge, because the checker recomputes the selected code from the port values that are sampled at the edge. The stimulus sets every input on the falling clock edge and holds it for a full cycle. It pulses `new_i` for single cycles, separated by idle gaps. It keeps the three codes distinct, so that an entry aimed at the wrong stage really does mismatch.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int unsigned NUM_STAGES = 3;
  localparam int unsigned STATE_W    = NUM_STAGES + 1;

  typedef enum logic [STATE_W-1:0] {
    ST_ERR    = 4'b0000,
    ST_FIRST  = 4'b0001,
    ST_SECOND = 4'b0010,
    ST_THIRD  = 4'b0100,
    ST_OPEN   = 4'b1000
  } lock_state_e;
endpackage

// File: rtl/lock_code_sel.sv
module lock_code_sel #(
  parameter int unsigned VAL_W = 4,
  parameter int unsigned NUM   = 3
) (
  input  logic [NUM-1:0]       sel_i,
  input  logic [NUM*VAL_W-1:0] codes_i,
  input  logic [VAL_W-1:0]     value_i,
  output logic                 match_o
);
  logic [VAL_W-1:0] picked [NUM+1];

  // AND-OR mux over one-hot select
  assign picked[0] = '0;
  for (genvar i = 0; i < NUM; i++) begin : g_mux
    assign picked[i+1] = picked[i] | (codes_i[i*VAL_W +: VAL_W] & {VAL_W{sel_i[i]}});
  end

  assign match_o = (|sel_i) && (value_i == picked[NUM]);
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import combo_lock_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic               new_i,
  input  logic               match_i,
  output logic [STATE_W-1:0] state_o
);
  always_comb begin
    unique case (state_i)
      ST_FIRST:  state_o = !new_i ? ST_FIRST  : (match_i ? ST_SECOND : ST_ERR);
      ST_SECOND: state_o = !new_i ? ST_SECOND : (match_i ? ST_THIRD  : ST_ERR);
      ST_THIRD:  state_o = !new_i ? ST_THIRD  : (match_i ? ST_OPEN   : ST_ERR);
      ST_OPEN:   state_o = ST_OPEN;
      ST_ERR:    state_o = ST_ERR;
      default:   state_o = ST_FIRST; // unused codes recover
    endcase
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int unsigned VAL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic [VAL_W-1:0] code1_i,
  input  logic [VAL_W-1:0] code2_i,
  input  logic [VAL_W-1:0] code3_i,
  output logic [2:0]       sel_o,
  output logic             open_o
);
  logic [STATE_W-1:0] state_q, state_d;
  logic               match;

  lock_code_sel #(
    .VAL_W(VAL_W),
    .NUM  (NUM_STAGES)
  ) i_code_sel (
    .sel_i  (state_q[NUM_STAGES-1:0]),
    .codes_i({code3_i, code2_i, code1_i}),
    .value_i(value_i),
    .match_o(match)
  );

  lock_next_state i_next_state (
    .state_i(state_q),
    .new_i  (new_i),
    .match_i(match),
    .state_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FIRST;
    else         state_q <= state_d;
  end

  // Encoding makes outputs plain state bits
  assign sel_o  = state_q[NUM_STAGES-1:0];
  assign open_o = state_q[STATE_W-1];
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int unsigned VAL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             new_i,
  input logic [VAL_W-1:0] value_i,
  input logic [VAL_W-1:0] code1_i,
  input logic [VAL_W-1:0] code2_i,
  input logic [VAL_W-1:0] code3_i,
  input logic [2:0]       sel_o,
  input logic             open_o
);
  logic [VAL_W-1:0] exp_code;
  logic             in_entry, in_err;

  always_comb begin
    case (sel_o)
      3'b001:  exp_code = code1_i;
      3'b010:  exp_code = code2_i;
      default: exp_code = code3_i;
    endcase
  end
  assign in_entry = |sel_o;
  assign in_err   = !open_o && (sel_o == 3'b000);

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_entry && !new_i) |=> ($stable(sel_o) && $stable(open_o))); // R2

  AST_STAGE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && (sel_o == 3'b001 || sel_o == 3'b010) && value_i == exp_code)
      |=> (sel_o == {$past(sel_o[1:0]), 1'b0}) && !open_o); // R3

  AST_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && sel_o == 3'b100 && value_i == code3_i) |=> (open_o && sel_o == 3'b000)); // R4

  AST_WRONG_TO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && in_entry && value_i != exp_code) |=> (sel_o == 3'b000 && !open_o)); // R5

  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> (open_o && sel_o == 3'b000)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_err |=> in_err); // R7

  AST_OUT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({open_o, sel_o}) <= 1); // R9
endmodule

bind combo_lock lock_checker #(.VAL_W(VAL_W)) i_lock_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .new_i  (new_i),
  .value_i(value_i),
  .code1_i(code1_i),
  .code2_i(code2_i),
  .code3_i(code3_i),
  .sel_o  (sel_o),
  .open_o (open_o)
);

// File: tb/test_combo_lock.sv
`timescale 1ns/1ps
module test_combo_lock;
  localparam int VAL_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             new_i = 1'b0;
  logic [VAL_W-1:0] value_i = '0;
  logic [VAL_W-1:0] code1_i = 4'd3;
  logic [VAL_W-1:0] code2_i = 4'd9;
  logic [VAL_W-1:0] code3_i = 4'd14;
  logic [2:0]       sel_o;
  logic             open_o;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i; // 125 MHz

  combo_lock #(.VAL_W(VAL_W)) i_combo_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_i(new_i), .value_i(value_i),
    .code1_i(code1_i), .code2_i(code2_i), .code3_i(code3_i),
    .sel_o(sel_o), .open_o(open_o)
  );

  // Reference model: 0..2 = waiting for code n, 3 = open, 4 = error
  int stage;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage <= 0;
    else if (new_i && stage < 3) begin
      int want;
      want = (stage == 0) ? int'(code1_i) : (stage == 1) ? int'(code2_i) : int'(code3_i);
      stage <= (int'(value_i) == want) ? stage + 1 : 4;
    end
  end

  task automatic check_out();
    logic [2:0] es;
    logic       eo;
    es = (stage == 0) ? 3'b001 : (stage == 1) ? 3'b010 : (stage == 2) ? 3'b100 : 3'b000;
    eo = (stage == 3);
    checks++;
    if (sel_o !== es || open_o !== eo) begin
      failures++;
      $display("FAIL %s: sel=%b open=%b expected sel=%b open=%b", cur_req, sel_o, open_o, es, eo);
    end
    checks++;
    if ($countones({open_o, sel_o}) > 1) begin // R9
      failures++;
      $display("FAIL R9: outputs %b%b expected at most one bit set", open_o, sel_o);
    end
  endtask

  task automatic cyc(input logic nw, input logic [VAL_W-1:0] v);
    @(negedge clk_i);
    check_out();
    new_i = nw;
    value_i = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd7);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    check_out();
    new_i = 1'b1;
    value_i = code1_i;
    rst_ni = 1'b0;
    #1 check_out(); // asynchronous effect
    @(negedge clk_i);
    check_out();
    rst_ni = 1'b1;
    new_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(2);
    rst_ni = 1'b1;
    idle(1);

    // correct sequence with idle gaps
    cur_req = "R2"; idle(3);
    cur_req = "R3"; cyc(1'b1, code1_i);
    cur_req = "R2"; idle(2);
    cur_req = "R3"; cyc(1'b1, code2_i);
    cur_req = "R2"; idle(2);
    cur_req = "R4"; cyc(1'b1, code3_i);
    idle(1);
    cur_req = "R6";
    cyc(1'b1, 4'd0); idle(1); cyc(1'b1, code1_i); idle(2);
    cur_req = "R10"; do_reset();
    cur_req = "R1"; idle(1);

    // error at first position
    cur_req = "R5"; cyc(1'b1, 4'd4); idle(1);
    cur_req = "R7";
    cyc(1'b1, code1_i); idle(1); cyc(1'b1, code2_i); idle(1); cyc(1'b1, code3_i); idle(2);
    cur_req = "R10"; do_reset();

    // error at second position
    cur_req = "R3"; idle(1); cyc(1'b1, code1_i); idle(1);
    cur_req = "R5"; cyc(1'b1, code1_i); idle(2);
    cur_req = "R10"; do_reset();

    // error at third position
    cur_req = "R3"; idle(1); cyc(1'b1, code1_i); cyc(1'b1, code2_i); idle(1);
    cur_req = "R5"; cyc(1'b1, 4'd15); idle(2);
    cur_req = "R10"; do_reset();

    // value equal to a non-selected code
    cur_req = "R8"; idle(1); cyc(1'b1, code2_i); idle(2);
    cur_req = "R10"; do_reset();
    cur_req = "R8"; idle(1); cyc(1'b1, code1_i); cyc(1'b1, code3_i); idle(2);
    cur_req = "R10"; do_reset();

    // different codes, back-to-back entries
    code1_i = 4'd0; code2_i = 4'd15; code3_i = 4'd5;
    cur_req = "R3"; idle(1); cyc(1'b1, 4'd0); cyc(1'b1, 4'd15);
    cur_req = "R4"; cyc(1'b1, 4'd5); idle(2);
    cur_req = "R6"; cyc(1'b1, 4'd5); idle(1);
    cur_req = "R10"; do_reset();
    cur_req = "R1"; idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule